// File: doc/BRIEF.md
# Two-Write Sequenced Reset Controller

This block turns an ordered pair of bus writes into board-level reset pulses. A host arms the controller with a first write. The value of that write picks a hard or a soft reset. A second write then fires the reset, and it must repeat the armed value with the "go" bit added. A hard reset drives the processor, PCI and ISA reset outputs together for a fixed number of clocks. A soft reset drives only the processor INIT line, for a shorter pulse.

The sequence can arrive in either of two forms:
- **I/O form.** Both writes go to one I/O-space control register.
- **Memory form.** The writes go to two adjacent memory addresses, one for arming and one for firing. This form serves hosts that cannot issue I/O cycles.

Any deviation from the sequence drops the controller back to idle without a reset. A completed pulse also drops it back to idle, so every reset needs a fresh pair of writes.

Top module: `rstseq_ctrl`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), all four reset outputs are low and nothing is armed. A trigger write alone then causes no pulse.
- R2: In the I/O form, the sequence is two I/O-space writes to address 0xCF9. The first writes data 0x02 and the second writes data 0x06. The processor, PCI and ISA reset outputs then go high in the first cycle after the second write is sampled, and stay high for exactly HARD_CYCLES clocks (default 16).
- R3: In the I/O form, a write of 0x00 followed by a write of 0x04 to 0xCF9 raises only `init_o`, for exactly INIT_CYCLES clocks (default 4). The pulse starts in the cycle after the second write.
- R4: In the memory form, the first write goes to 0xFFFFFFF0 and the second goes to 0xFFFFFFF4. The data values are the same as in the I/O form. The pair 0x02/0x06 gives the hard pulse of R2, and the pair 0x00/0x04 gives the soft pulse of R3.
- R5: Data bit 1 of the arming write selects hard (1) or soft (0). Data bit 2 is the go bit. The only accepted second write is the arming value with bit 2 set. Any other value written to a sequence address while armed returns the controller to idle with no pulse.
- R6: A first write whose data is not 0x00 or 0x02 does not arm the controller.
- R7: Writes to any other address do not disturb an armed sequence. This includes a memory-space write to 0xCF9 and I/O-space writes to the two memory addresses.
- R8: In the memory form, only 0xFFFFFFF0 can arm and only 0xFFFFFFF4 can fire. A second write to 0xFFFFFFF0 while armed returns the controller to idle.
- R9: A sequence armed in one form and completed in the other produces no pulse.
- R10: While a pulse runs, all writes are ignored and the pulse length is unchanged. When the pulse ends the controller is idle, so a lone trigger write produces no pulse.
- R11: The three hard-reset outputs are always equal to each other, and they are never high in the same cycle as `init_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_io | input | 1 | 1 = I/O-space write, 0 = memory-space write |
| wr_addr | input | 32 | Write address |
| wr_data | input | 8 | Write data |
| cpu_rst_o | output | 1 | Processor hard reset |
| pci_rst_o | output | 1 | PCI bus reset |
| isa_rst_o | output | 1 | ISA bus reset |
| init_o | output | 1 | Processor INIT (soft reset) |

## Verification
The assertions assume the following about the inputs:
- `wr_en` is a single-cycle strobe, and address and data are known whenever it is high.
- Reset is held low for more than one clock, so a run-length counter that is cut short by reset is never judged.

The bench respects these assumptions. It drives each write as a one-cycle pulse placed half a cycle away from the sampling edge. It holds reset low for three or more cycles, including when reset interrupts a running pulse. Between table vectors it issues a flushing write, so every vector starts from idle.

// File: rtl/rstseq_pkg.sv
// Shared types for the two-write reset sequencer.
// Assumes: nothing; pure type definitions.
package rstseq_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } seq_state_t;

    // Which bus form started the sequence
    typedef enum logic {
        PATH_IO  = 1'b0,
        PATH_MEM = 1'b1
    } seq_path_t;

    // Address decode result for one write
    typedef struct packed {
        logic io_hit;        // I/O write to the control register
        logic mem_arm_hit;   // memory write to the arming address
        logic mem_fire_hit;  // memory write to the firing address
    } site_hit_t;

endpackage

// File: rtl/rstseq_decode.sv
// Address decoder: classifies one bus write against the sequence addresses.
// Assumes: wr_addr/wr_io are valid whenever wr_en is high.
module rstseq_decode
    import rstseq_pkg::*;
#(
    parameter int          ADDR_W        = 32,
    parameter logic [31:0] IO_ADDR       = 32'h0000_0CF9,
    parameter logic [31:0] MEM_ARM_ADDR  = 32'hFFFF_FFF0,
    parameter logic [31:0] MEM_FIRE_ADDR = 32'hFFFF_FFF4
) (
    input  logic              wr_en,
    input  logic              wr_io,
    input  logic [ADDR_W-1:0] wr_addr,
    output site_hit_t         hit
);
    localparam logic [ADDR_W-1:0] IO_A   = ADDR_W'(IO_ADDR);
    localparam logic [ADDR_W-1:0] ARM_A  = ADDR_W'(MEM_ARM_ADDR);
    localparam logic [ADDR_W-1:0] FIRE_A = ADDR_W'(MEM_FIRE_ADDR);

    // Match the write against each of the three sequence sites
    always_comb begin
        hit.io_hit       = wr_en &&  wr_io && (wr_addr == IO_A);
        hit.mem_arm_hit  = wr_en && !wr_io && (wr_addr == ARM_A);
        hit.mem_fire_hit = wr_en && !wr_io && (wr_addr == FIRE_A);
    end
endmodule

// File: rtl/rstseq_fsm.sv
// Sequencer: tracks the arm/fire write pair and launches the reset pulse.
// Assumes: 'hit' comes from rstseq_decode; pulse_done is high for one cycle
// at the last cycle of a pulse.
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SEL_BIT = 1,
    parameter int GO_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  site_hit_t         hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pulse_done,
    output logic              start_o,
    output logic              start_hard_o,
    output logic              armed_o,
    output logic              firing_o
);
    localparam logic [DATA_W-1:0] SEL_MASK = DATA_W'(1) << SEL_BIT;
    localparam logic [DATA_W-1:0] GO_MASK  = DATA_W'(1) << GO_BIT;

    seq_state_t  state_q, state_d;
    seq_path_t   path_q,  path_d;
    logic        hard_q,  hard_d;
    logic        any_hit, arm_ok, trig_site, trig_ok;
    logic [DATA_W-1:0] expect_val;

    // Classify the current write for arming and firing
    always_comb begin
        any_hit    = hit.io_hit | hit.mem_arm_hit | hit.mem_fire_hit;
        arm_ok     = (wr_data & ~SEL_MASK) == '0;
        expect_val = (hard_q ? SEL_MASK : '0) | GO_MASK;
        trig_site  = (path_q == PATH_IO) ? hit.io_hit : hit.mem_fire_hit;
        trig_ok    = trig_site && (wr_data == expect_val);
    end

    // Next-state logic of the sequencer
    always_comb begin
        state_d = state_q;
        path_d  = path_q;
        hard_d  = hard_q;
        start_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if ((hit.io_hit || hit.mem_arm_hit) && arm_ok) begin
                    state_d = ST_ARMED;
                    path_d  = hit.io_hit ? PATH_IO : PATH_MEM;
                    hard_d  = wr_data[SEL_BIT];
                end
            end
            ST_ARMED: begin
                if (any_hit) begin
                    if (trig_ok) begin
                        state_d = ST_FIRE;
                        start_o = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_FIRE: begin
                if (pulse_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            path_q  <= PATH_IO;
            hard_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            path_q  <= path_d;
            hard_q  <= hard_d;
        end
    end

    assign start_hard_o = hard_q;
    assign armed_o      = (state_q == ST_ARMED);
    assign firing_o     = (state_q == ST_FIRE);

    // A pulse is only entered from the armed state
    assert_fire_from_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_FIRE) |-> $past(state_q) == ST_ARMED)
        else $error("fire entered without arming");
endmodule

// File: rtl/rstseq_pulse.sv
// Pulse generator: drives the hard-reset group or INIT for a fixed length.
// Assumes: start is a single-cycle request that never arrives mid-pulse.
module rstseq_pulse #(
    parameter int HARD_CYCLES = 16,
    parameter int INIT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_hard,
    output logic hard_o,
    output logic init_o,
    output logic busy_o,
    output logic done_o
);
    localparam int LEN_MAX = (HARD_CYCLES > INIT_CYCLES) ? HARD_CYCLES : INIT_CYCLES;
    localparam int CNT_W   = $clog2(LEN_MAX + 1);
    localparam logic [CNT_W-1:0] HARD_LOAD = CNT_W'(HARD_CYCLES - 1);
    localparam logic [CNT_W-1:0] INIT_LOAD = CNT_W'(INIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, hard_q, init_q;

    // Last cycle of the running pulse
    assign done_o = busy_q && (cnt_q == '0);

    // Load, count down and release the pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            hard_q <= 1'b0;
            init_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= start_hard ? HARD_LOAD : INIT_LOAD;
            busy_q <= 1'b1;
            hard_q <= start_hard;
            init_q <= !start_hard;
        end else if (done_o) begin
            busy_q <= 1'b0;
            hard_q <= 1'b0;
            init_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign hard_o = hard_q;
    assign init_o = init_q;
    assign busy_o = busy_q;

    // Run-length counters used only by the length checks
    logic [CNT_W:0] run_hard_q, run_init_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_hard_q <= '0;
            run_init_q <= '0;
        end else begin
            run_hard_q <= hard_q ? run_hard_q + 1'b1 : '0;
            run_init_q <= init_q ? run_init_q + 1'b1 : '0;
        end
    end

    assert_hard_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hard_q) |-> run_hard_q == (CNT_W+1)'(HARD_CYCLES))
        else $error("hard pulse length wrong");

    assert_init_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_q) |-> run_init_q == (CNT_W+1)'(INIT_CYCLES))
        else $error("init pulse length wrong");

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hard_q && init_q))
        else $error("hard and init overlap");
endmodule

// File: rtl/rstseq_ctrl.sv
// Top: two-write sequenced reset controller (I/O and memory-mapped forms).
// Assumes: wr_en is a one-cycle strobe; rst_n is synchronous, active low.
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int          ADDR_W        = 32,
    parameter int          DATA_W        = 8,
    parameter logic [31:0] IO_ADDR       = 32'h0000_0CF9,
    parameter logic [31:0] MEM_ARM_ADDR  = 32'hFFFF_FFF0,
    parameter logic [31:0] MEM_FIRE_ADDR = 32'hFFFF_FFF4,
    parameter int          HARD_CYCLES   = 16,
    parameter int          INIT_CYCLES   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_io,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cpu_rst_o,
    output logic              pci_rst_o,
    output logic              isa_rst_o,
    output logic              init_o
);
    site_hit_t hit;
    logic start, start_hard, armed, firing;
    logic hard_pulse, busy, done;

    rstseq_decode #(
        .ADDR_W(ADDR_W), .IO_ADDR(IO_ADDR),
        .MEM_ARM_ADDR(MEM_ARM_ADDR), .MEM_FIRE_ADDR(MEM_FIRE_ADDR)
    ) u_decode (
        .wr_en(wr_en), .wr_io(wr_io), .wr_addr(wr_addr), .hit(hit)
    );

    rstseq_fsm #(.DATA_W(DATA_W), .SEL_BIT(1), .GO_BIT(2)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hit(hit), .wr_data(wr_data),
        .pulse_done(done), .start_o(start), .start_hard_o(start_hard),
        .armed_o(armed), .firing_o(firing)
    );

    rstseq_pulse #(.HARD_CYCLES(HARD_CYCLES), .INIT_CYCLES(INIT_CYCLES)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start(start), .start_hard(start_hard),
        .hard_o(hard_pulse), .init_o(init_o), .busy_o(busy), .done_o(done)
    );

    // Fan the hard pulse out to the three reset domains
    assign cpu_rst_o = hard_pulse;
    assign pci_rst_o = hard_pulse;
    assign isa_rst_o = hard_pulse;

    // Sequencer fire state and pulse generator stay in step
    assert_fire_tracks_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        firing == busy)
        else $error("sequencer and pulse out of step");

    // Once a pulse ends the sequencer is idle, not armed
    assert_idle_after_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!armed && !firing))
        else $error("not idle after pulse");
endmodule

// File: tb/tb_rstseq_ctrl.sv
module tb_rstseq_ctrl;
    localparam int HARD_LEN = 16;
    localparam int INIT_LEN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_io = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cpu_rst_o, pci_rst_o, isa_rst_o, init_o;

    int tests = 0;
    int fails = 0;
    int hard_seen = 0;
    int init_seen = 0;
    int bad_group = 0;

    always #2 clk = ~clk;

    rstseq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_io(wr_io),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .cpu_rst_o(cpu_rst_o), .pci_rst_o(pci_rst_o),
        .isa_rst_o(isa_rst_o), .init_o(init_o)
    );

    // Count pulse cycles and R11 violations at every falling edge
    always @(negedge clk) begin
        if (cpu_rst_o) hard_seen++;
        if (init_o) init_seen++;
        if (cpu_rst_o != pci_rst_o || pci_rst_o != isa_rst_o || (cpu_rst_o && init_o))
            bad_group++;
    end

    typedef struct packed {
        logic        io1;
        logic [31:0] a1;
        logic [7:0]  d1;
        logic        io2;
        logic [31:0] a2;
        logic [7:0]  d2;
        logic [7:0]  exp_hard;
        logic [7:0]  exp_init;
    } vec_t;

    localparam logic [31:0] IOA = 32'h0000_0CF9;
    localparam logic [31:0] MA  = 32'hFFFF_FFF0;
    localparam logic [31:0] MF  = 32'hFFFF_FFF4;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, IOA, 8'h02, 1'b1, IOA, 8'h06, 8'd16, 8'd0},  // R2
        '{1'b1, IOA, 8'h00, 1'b1, IOA, 8'h04, 8'd0,  8'd4},  // R3
        '{1'b0, MA,  8'h02, 1'b0, MF,  8'h06, 8'd16, 8'd0},  // R4 hard
        '{1'b0, MA,  8'h00, 1'b0, MF,  8'h04, 8'd0,  8'd4},  // R4 soft
        '{1'b1, IOA, 8'h02, 1'b1, IOA, 8'h04, 8'd0,  8'd0},  // R5
        '{1'b1, IOA, 8'h00, 1'b1, IOA, 8'h06, 8'd0,  8'd0},  // R5
        '{1'b1, IOA, 8'h03, 1'b1, IOA, 8'h07, 8'd0,  8'd0},  // R6
        '{1'b1, IOA, 8'h01, 1'b1, IOA, 8'h05, 8'd0,  8'd0},  // R6
        '{1'b0, MF,  8'h02, 1'b0, MF,  8'h06, 8'd0,  8'd0},  // R8 arm at fire site
        '{1'b0, MA,  8'h02, 1'b0, MA,  8'h06, 8'd0,  8'd0},  // R8 fire at arm site
        '{1'b1, IOA, 8'h02, 1'b0, MF,  8'h06, 8'd0,  8'd0},  // R9
        '{1'b0, MA,  8'h02, 1'b1, IOA, 8'h06, 8'd0,  8'd0},  // R9
        '{1'b0, IOA, 8'h02, 1'b0, IOA, 8'h06, 8'd0,  8'd0},  // R7 memory write to I/O addr
        '{1'b1, MA,  8'h02, 1'b1, MF,  8'h06, 8'd0,  8'd0}   // R7 I/O writes to mem addrs
    };

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic io, input logic [31:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_io = io; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic clear_counts();
        hard_seen = 0; init_seen = 0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        check("R1 cpu_rst low in reset", cpu_rst_o, 0);
        check("R1 init low in reset", init_o, 0);
        rst_n = 1'b1;
        // R1: lone trigger after reset does nothing
        clear_counts();
        wr(1'b1, IOA, 8'h06);
        wait_cycles(24);
        check("R1 lone trigger hard", hard_seen, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            wr(1'b1, IOA, 8'hFF);   // flush to idle
            wr(VECS[i].io1, VECS[i].a1, VECS[i].d1);
            clear_counts();
            wr(VECS[i].io2, VECS[i].a2, VECS[i].d2);
            @(negedge clk); #1;
            check($sformatf("vec%0d start cycle (R2/R3/R4)", i),
                  int'(cpu_rst_o) + int'(init_o),
                  (VECS[i].exp_hard != 0 || VECS[i].exp_init != 0) ? 1 : 0);
            wait_cycles(24);
            check($sformatf("vec%0d hard cycles (R2/R4/R5-R9)", i), hard_seen, int'(VECS[i].exp_hard));
            check($sformatf("vec%0d init cycles (R3/R4/R5-R9)", i), init_seen, int'(VECS[i].exp_init));
        end

        // R7: unrelated writes keep the armed state
        wr(1'b1, IOA, 8'hFF);
        wr(1'b1, IOA, 8'h02);
        wr(1'b1, 32'h0000_0080, 8'h55);
        wr(1'b0, 32'h0000_1000, 8'h06);
        clear_counts();
        wr(1'b1, IOA, 8'h06);
        wait_cycles(24);
        check("R7 armed survives unrelated writes", hard_seen, HARD_LEN);

        // R5: after a mismatched trigger, a correct trigger alone is not enough
        wr(1'b0, MA, 8'h00);
        wr(1'b0, MF, 8'h06);
        clear_counts();
        wr(1'b0, MF, 8'h04);
        wait_cycles(24);
        check("R5 idle after mismatch", init_seen, 0);

        // R10: writes during pulse ignored, idle afterwards
        wr(1'b1, IOA, 8'h02);
        clear_counts();
        wr(1'b1, IOA, 8'h06);
        wr(1'b1, IOA, 8'h02);
        wr(1'b1, IOA, 8'h06);
        wait_cycles(40);
        check("R10 pulse length unchanged by writes", hard_seen, HARD_LEN);
        clear_counts();
        wr(1'b1, IOA, 8'h06);
        wait_cycles(24);
        check("R10 lone trigger after pulse", hard_seen, 0);
        wr(1'b0, MA, 8'h00);
        clear_counts();
        wr(1'b0, MF, 8'h04);
        wait_cycles(24);
        check("R10 fresh sequence after pulse", init_seen, INIT_LEN);

        // R1: reset during a pulse clears outputs and the sequence
        wr(1'b1, IOA, 8'h02);
        wr(1'b1, IOA, 8'h06);
        wait_cycles(3);
        rst_n = 1'b0;
        wait_cycles(1);
        check("R1 reset cuts pulse", int'(cpu_rst_o) + int'(isa_rst_o), 0);
        wait_cycles(3);
        rst_n = 1'b1;
        clear_counts();
        wr(1'b1, IOA, 8'h06);
        wait_cycles(24);
        check("R1 no arm after reset", hard_seen, 0);

        check("R11 group equal and exclusive", bad_group, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule